// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block brings an asynchronous DRAM out of power-up and keeps its contents alive afterwards. Once reset is released it counts out a long power-up pause, then asks the access controller for the memory bus and runs a fixed number of wake-up refresh cycles. When the last of them has finished it raises `init_done`. Until then the access controller must keep ordinary reads and writes off the bus.

In normal operation an interval timer raises a refresh request at a fixed period, chosen so that every row is refreshed within the retention window. Each refresh is a CAS-before-RAS cycle. The column strobes go low first, the row strobe then falls while they are still low, the row strobe is held low for its minimum width, and all strobes then go high for the precharge time. The block drives the strobes only while it owns the bus, and it keeps its request up until the precharge has finished.

If a pending request goes without a grant for longer than a set slack, the block treats the refresh deadline as missed. It sets a sticky flag, withdraws `init_done` and runs the whole wake-up sequence again.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted, `bus_req`, `drv_en`, `init_done` and `deadline_miss` are 0 and `ras_n`, `lcas_n` and `ucas_n` are 1.
- R2: `bus_req` stays 0 for the first PAUSE_CYC clock edges after reset release and goes to 1 right after edge PAUSE_CYC.
- R3: `init_done` goes to 1 right after the edge that ends the precharge of the WAKE_CNT-th wake-up refresh. No earlier refresh sets it.
- R4: In every refresh cycle the enabled column strobes go low CAS_LEAD cycles before `ras_n` falls, and they stay low for as long as `ras_n` is low.
- R5: `ras_n` is low for exactly RAS_LOW_CYC cycles per refresh. It is followed by RAS_PRE_CYC precharge cycles in which all strobes are high and `drv_en` is still 1.
- R6: A refresh cycle, and with it `drv_en`, starts only on a clock edge where `bus_gnt` is 1 while the block is requesting. When `drv_en` is 0 all strobes are high. `bus_req` is 1 whenever `drv_en` is 1.
- R7: After initialisation a refresh request is raised every INTERVAL_CYC cycles. With a fixed grant latency, consecutive refresh cycles therefore start exactly INTERVAL_CYC cycles apart.
- R8: If a refresh request stays ungranted for SLACK_CYC edges, `deadline_miss` goes to 1 and stays there until reset. `init_done` drops to 0, and WAKE_CNT wake-up refreshes run again before `init_done` returns.
- R9: CAS_MASK bit 0 enables `lcas_n` and bit 1 enables `ucas_n`. A disabled column strobe stays 1 at all times. A mask of 0 enables both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| bus_gnt | input | 1 | Access controller hands the memory bus to this block |
| bus_req | output | 1 | Request for the memory bus, held high through the whole refresh cycle |
| drv_en | output | 1 | This block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| init_done | output | 1 | Power-up and wake-up complete; ordinary accesses are allowed |
| deadline_miss | output | 1 | Sticky flag: a refresh request waited longer than the slack |

## Verification
The main function is exercised through the grant pattern. A grant that arrives a few cycles after each request checks the pause length, the wake-up count and the strobe ordering and widths. Because that latency is constant, it also shows whether the spacing between refreshes matches the interval. A window in which the grant is withheld entirely separates a design that merely waits from one that detects the deadline, raises the flag and repeats the wake-up cycles. A reference model driven by the same grant predicts every output on every cycle, and running with only the lower column strobe enabled checks that the masked strobe never moves.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_WAKE  = 2'd1,
    ST_RUN   = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CAS  = 2'd1,
    PH_RAS  = 2'd2,
    PH_PRE  = 2'd3
  } cbr_phase_e;

endpackage

// File: rtl/ref_down_timer.sv
module ref_down_timer #(
  parameter int unsigned WIDTH   = 16,
  parameter int unsigned RST_VAL = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             en,
  output logic             zero
);

  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= WIDTH'(RST_VAL);
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ref_slack_guard.sv
module ref_slack_guard #(
  parameter int unsigned SLACK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic count_en,
  output logic expired
);

  localparam int unsigned SW = $clog2(SLACK_CYC + 1);

  logic [SW-1:0] wait_q, wait_d;

  always_comb begin
    wait_d = wait_q;
    if (clear) begin
      wait_d = '0;
    end else if (count_en) begin
      wait_d = wait_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else begin
      wait_q <= wait_d;
    end
  end

  assign expired = count_en && (wait_q == SW'(SLACK_CYC - 1));

endmodule

// File: rtl/ref_cbr_seq.sv
module ref_cbr_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned CAS_LEAD    = 3,
  parameter int unsigned RAS_LOW_CYC = 15,
  parameter int unsigned RAS_PRE_CYC = 10,
  parameter logic [1:0]  CAS_MASK    = 2'b11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n
);

  localparam int unsigned MX1 = (CAS_LEAD > RAS_LOW_CYC) ? CAS_LEAD : RAS_LOW_CYC;
  localparam int unsigned MX  = (MX1 > RAS_PRE_CYC) ? MX1 : RAS_PRE_CYC;
  localparam int unsigned CW  = $clog2(MX + 1);
  localparam logic [1:0]  EFF_MASK = (CAS_MASK == 2'b00) ? 2'b11 : CAS_MASK;

  cbr_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cas_low;
  logic [1:0]    lane_n;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_CAS;
          cnt_d = CW'(CAS_LEAD - 1);
        end
      end
      PH_CAS: begin
        if (cnt_q == '0) begin
          ph_d  = PH_RAS;
          cnt_d = CW'(RAS_LOW_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_RAS: begin
        if (cnt_q == '0) begin
          ph_d  = PH_PRE;
          cnt_d = CW'(RAS_PRE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PRE: begin
        if (cnt_q == '0) begin
          ph_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy    = (ph_q != PH_IDLE);
  assign done    = (ph_q == PH_PRE) && (cnt_q == '0);
  assign ras_n   = (ph_q != PH_RAS);
  assign cas_low = (ph_q == PH_CAS) || (ph_q == PH_RAS);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    if (EFF_MASK[g]) begin : g_on
      assign lane_n[g] = !cas_low;
    end else begin : g_off
      assign lane_n[g] = 1'b1;
    end
  end

  assign lcas_n = lane_n[0];
  assign ucas_n = lane_n[1];

  // Checking counters for strobe widths
  logic [CW:0] lo_run_q;
  logic [CW:0] hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run_q <= '0;
      hi_run_q <= (CW+1)'(RAS_PRE_CYC);
    end else begin
      lo_run_q <= ras_n ? '0 : lo_run_q + 1'b1;
      if (!ras_n) begin
        hi_run_q <= '0;
      end else if (hi_run_q < (CW+1)'(RAS_PRE_CYC)) begin
        hi_run_q <= hi_run_q + 1'b1;
      end
    end
  end

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(!lcas_n || !ucas_n) && (!lcas_n || !ucas_n))); // R4
  AST_CAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (!lcas_n || !ucas_n)); // R4
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (lo_run_q == (CW+1)'(RAS_LOW_CYC))); // R5
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_run_q >= (CW+1)'(RAS_PRE_CYC))); // R5

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 50000,
  parameter int unsigned WAKE_CNT     = 8,
  parameter int unsigned INTERVAL_CYC = 3900,
  parameter int unsigned SLACK_CYC    = 1000,
  parameter int unsigned CAS_LEAD     = 3,
  parameter int unsigned RAS_LOW_CYC  = 15,
  parameter int unsigned RAS_PRE_CYC  = 10,
  parameter logic [1:0]  CAS_MASK     = 2'b11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_gnt,
  output logic bus_req,
  output logic drv_en,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n,
  output logic init_done,
  output logic deadline_miss
);

  localparam int unsigned TMAX = (PAUSE_CYC > INTERVAL_CYC) ? PAUSE_CYC : INTERVAL_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned WW   = $clog2(WAKE_CNT + 1);

  seq_state_e    st_q, st_d;
  logic [WW-1:0] wake_q, wake_d;
  logic          pend_q, pend_d;
  logic          init_q, init_d;
  logic          miss_q, miss_d;

  logic          tmr_load, tmr_en, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          tick, need, start;
  logic          slack_cnt_en, slack_exp;
  logic          seq_busy, seq_done;

  ref_down_timer #(
    .WIDTH   (TW),
    .RST_VAL (PAUSE_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .en       (tmr_en),
    .zero     (tmr_zero)
  );

  ref_slack_guard #(
    .SLACK_CYC (SLACK_CYC)
  ) u_slack (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tick),
    .count_en (slack_cnt_en),
    .expired  (slack_exp)
  );

  ref_cbr_seq #(
    .CAS_LEAD    (CAS_LEAD),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .RAS_PRE_CYC (RAS_PRE_CYC),
    .CAS_MASK    (CAS_MASK)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (seq_busy),
    .done   (seq_done),
    .ras_n  (ras_n),
    .lcas_n (lcas_n),
    .ucas_n (ucas_n)
  );

  assign need  = (st_q == ST_WAKE) || ((st_q == ST_RUN) && pend_q);
  assign start = need && bus_gnt && !seq_busy;
  assign tick  = (st_q == ST_RUN) && tmr_zero;
  assign slack_cnt_en = (st_q == ST_RUN) && pend_q && !start && !tick;

  always_comb begin
    st_d     = st_q;
    wake_d   = wake_q;
    pend_d   = pend_q;
    init_d   = init_q;
    miss_d   = miss_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(INTERVAL_CYC - 1);
    tmr_en   = 1'b0;
    unique case (st_q)
      ST_PAUSE: begin
        tmr_en = 1'b1;
        if (tmr_zero) begin
          st_d   = ST_WAKE;
          wake_d = WW'(WAKE_CNT);
        end
      end
      ST_WAKE: begin
        if (seq_done) begin
          if (wake_q == WW'(1)) begin
            st_d     = ST_RUN;
            init_d   = 1'b1;
            pend_d   = 1'b0;
            tmr_load = 1'b1;
          end else begin
            wake_d = wake_q - 1'b1;
          end
        end
      end
      ST_RUN: begin
        tmr_en = 1'b1;
        if (tick) begin
          tmr_load = 1'b1;
          pend_d   = 1'b1;
        end else if (start) begin
          pend_d = 1'b0;
        end else if (pend_q && slack_exp) begin
          miss_d = 1'b1;
          init_d = 1'b0;
          pend_d = 1'b0;
          st_d   = ST_WAKE;
          wake_d = WW'(WAKE_CNT);
        end
      end
      default: st_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_PAUSE;
      wake_q <= '0;
      pend_q <= 1'b0;
      init_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_q <= wake_d;
      pend_q <= pend_d;
      init_q <= init_d;
      miss_q <= miss_d;
    end
  end

  assign bus_req       = need || seq_busy;
  assign drv_en        = seq_busy;
  assign init_done     = init_q;
  assign deadline_miss = miss_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> (ras_n && lcas_n && ucas_n)); // R6
  AST_GNT_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_en) |-> $past(bus_gnt && bus_req)); // R6
  AST_REQ_COVERS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> bus_req); // R6
  AST_INIT_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (st_q == ST_RUN)); // R3
  AST_MISS_DROPS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(deadline_miss) |-> !init_done); // R8
  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(deadline_miss) |-> deadline_miss); // R8

endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb_top;

  localparam int P  = 40;
  localparam int W  = 8;
  localparam int IV = 60;
  localparam int SL = 10;
  localparam int CL = 2;
  localparam int RL = 3;
  localparam int RP = 2;
  localparam int LEN = CL + RL + RP;
  localparam int GNT_DLY = 3;

  logic clk, rst_n, bus_gnt;
  logic bus_req, drv_en, ras_n, lcas_n, ucas_n, init_done, deadline_miss;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit hold_off = 1'b0;
  int req_age = 0;

  dram_refresh_seq #(
    .PAUSE_CYC (P), .WAKE_CNT (W), .INTERVAL_CYC (IV), .SLACK_CYC (SL),
    .CAS_LEAD (CL), .RAS_LOW_CYC (RL), .RAS_PRE_CYC (RP), .CAS_MASK (2'b01)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .bus_gnt (bus_gnt), .bus_req (bus_req),
    .drv_en (drv_en), .ras_n (ras_n), .lcas_n (lcas_n), .ucas_n (ucas_n),
    .init_done (init_done), .deadline_miss (deadline_miss)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Behavioural reference model
  int  m_since, m_mode, m_pos, m_wdone, m_wait, m_iv;
  bit  m_pend, m_init, m_miss;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_since = 0; m_mode = 0; m_pos = -1; m_wdone = 0; m_wait = 0; m_iv = 0;
      m_pend = 0; m_init = 0; m_miss = 0;
    end else begin
      bit need, st, fin;
      int o_mode;
      need   = (m_mode == 1) || (m_mode == 2 && m_pend);
      st     = need && bus_gnt && (m_pos < 0);
      fin    = (m_pos == LEN - 1);
      o_mode = m_mode;
      m_since++;
      if (st) m_pos = 0;
      else if (fin) m_pos = -1;
      else if (m_pos >= 0) m_pos++;
      case (o_mode)
        0: if (m_since == P) begin m_mode = 1; m_wdone = 0; end
        1: if (fin) begin
             m_wdone++;
             if (m_wdone == W) begin m_mode = 2; m_init = 1; m_iv = 0; m_pend = 0; end
           end
        default: begin
          m_iv++;
          if (m_iv == IV) begin m_iv = 0; m_pend = 1; m_wait = 0; end
          else if (st) m_pend = 0;
          else if (m_pend) begin
            m_wait++;
            if (m_wait == SL) begin
              m_miss = 1; m_init = 0; m_mode = 1; m_wdone = 0; m_pend = 0;
            end
          end
        end
      endcase
    end
  end

  // Grant policy and per-cycle comparison at the falling edge
  int  ras_falls = 0;
  int  falls_at_init[$];
  int  last_start = -1;
  logic prev_ras = 1'b1, prev_drv = 1'b0, prev_init = 1'b0, prev_miss = 1'b0;
  bit  ucas_moved = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      req_age = 0;
      bus_gnt = 1'b0;
    end else begin
      bit e_drv, e_ras_low, e_cas_low, e_req;
      e_drv     = (m_pos >= 0);
      e_ras_low = (m_pos >= CL) && (m_pos < CL + RL);
      e_cas_low = (m_pos >= 0) && (m_pos < CL + RL);
      e_req     = (m_mode == 1) || (m_mode == 2 && m_pend) || e_drv;
      chk("R2 bus_req", bus_req, e_req);
      chk("R6 drv_en", drv_en, e_drv);
      chk("R5 ras_n", ras_n, !e_ras_low);
      chk("R4 lcas_n", lcas_n, !e_cas_low);
      chk("R9 ucas_n", ucas_n, 1'b1);
      chk("R3 init_done", init_done, m_init);
      chk("R8 deadline_miss", deadline_miss, m_miss);
      if (prev_ras && !ras_n) ras_falls++;
      if (!ucas_n) ucas_moved = 1'b1;
      if (!prev_init && init_done) falls_at_init.push_back(ras_falls);
      if (!prev_miss && deadline_miss) ras_falls = 0;
      if (!prev_drv && drv_en && init_done) begin
        if (last_start >= 0) chk("R7 refresh spacing", (cyc - last_start) == IV, 1'b1);
        last_start = cyc;
      end
      if (!init_done) last_start = -1;
      prev_ras = ras_n; prev_drv = drv_en; prev_init = init_done; prev_miss = deadline_miss;
      if (bus_req) req_age++; else req_age = 0;
      bus_gnt = !hold_off && (req_age >= GNT_DLY);
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_gnt = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bus_req", bus_req, 1'b0);
    chk("R1 drv_en", drv_en, 1'b0);
    chk("R1 ras_n", ras_n, 1'b1);
    chk("R1 lcas_n", lcas_n, 1'b1);
    chk("R1 ucas_n", ucas_n, 1'b1);
    chk("R1 init_done", init_done, 1'b0);
    chk("R1 deadline_miss", deadline_miss, 1'b0);
    rst_n = 1'b1;
    wait (init_done === 1'b1);
    repeat (4 * IV) @(negedge clk);
    hold_off = 1'b1;
    wait (deadline_miss === 1'b1);
    repeat (5) @(negedge clk);
    hold_off = 1'b0;
    wait (init_done === 1'b1);
    repeat (3 * IV) @(negedge clk);
    chk("R3 wake-up count", (falls_at_init.size() >= 1) && (falls_at_init[0] == W), 1'b1);
    chk("R8 repeated wake-up count", (falls_at_init.size() == 2) && (falls_at_init[1] == W), 1'b1);
    chk("R9 upper strobe idle", ucas_moved, 1'b0);
    finish_run();
  end

  initial begin
    #80000;
    errors++;
    $display("FAIL watchdog at cycle %0d: actual hung expected finished", cyc);
    finish_run();
  end

endmodule